// File: doc/BRIEF.md
# Port Edge Wake-Up Interrupt Unit

This block watches an input port of `WIDTH` pins (eight by default) and turns chosen signal edges into interrupt and wake-up events. Each pin has its own edge polarity bit, its own active-low enable bit and its own sticky pending flag. The three values are held in three software-writable registers, and each register can be read back at the outputs.

Each pin passes through a two-flop synchronizer before the edge detector. When an enabled pin shows an edge of the selected polarity and its pending flag is clear, the flag is set and `irq` pulses for one cycle. Only software clears a flag, by writing a 1 to its position. While a flag stays set, its pin raises no further interrupts. `wake` stays high as long as any enabled pin has its flag set. A sleep controller uses it to resume the core.

Top module: `pin_edge_wake`

## Requirements
- R1: After reset `edge_sel` is all ones (falling edges), `en_n` is all ones (all pins disabled), `pend` is zero, and `irq` and `wake` are low.
- R2: Bit value 1 in `edge_sel` selects a falling edge for that pin and 0 selects a rising edge. An edge of the other polarity leaves the pin's pending bit unchanged.
- R3: The enable bit is active low. An edge on a pin whose `en_n` bit is 1 sets no pending bit and causes no `irq`.
- R4: Suppose a pin change is present before rising clock edge k. It first shows in `pend` and `irq` after edge k+2, because two synchronizer flops and one previous-value flop lie on the path.
- R5: Pending bits are never cleared by hardware. A pend write clears exactly the bit positions where `wdata` is 1, and bits written with 0 keep their value.
- R6: A pin whose pending bit is already set gives no `irq` pulse for further edges.
- R7: Suppose a pend write clears a bit in the same cycle that a qualifying edge arrives on that pin. The bit stays set and `irq` pulses, because the set wins.
- R8: `irq` is high for exactly one cycle per new event, in the cycle in which the new pending bit first reads as set.
- R9: `wake` is high exactly while at least one pin has both its pending bit set and its `en_n` bit 0.
- R10: A write strobe for `edge_sel` or `en_n` loads all of `wdata` into that register. The new value reads back after the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pins | input | WIDTH | Asynchronous port pins |
| edge_we | input | 1 | Write strobe for the edge polarity register |
| en_we | input | 1 | Write strobe for the enable register |
| pend_we | input | 1 | Write strobe that clears pending bits (write 1 to clear) |
| wdata | input | WIDTH | Write data shared by the three strobes |
| edge_sel | output | WIDTH | Edge polarity register, 1 = falling |
| en_n | output | WIDTH | Enable register, 0 = enabled |
| pend | output | WIDTH | Sticky pending flags |
| irq | output | 1 | One-cycle interrupt pulse per new event |
| wake | output | 1 | Level wake request |

## Verification
A wrong synchronizer depth or a wrong previous-value register moves the first visible `pend` bit and the `irq` pulse away from edge k+2. The bench checks that exact cycle, so such an error shows within three clocks of the pin change. A pending bit that the hardware loses or sets wrongly stays visible on `pend` until software writes it. It is caught at the next vector sample and is often also seen as a wrong `wake` level. Errors in the suppression logic or in the set-versus-clear priority show up as an extra or a missing `irq` pulse inside the few-cycle window after a stimulus edge.

// File: rtl/pin_edge_wake.sv
module pin_edge_wake #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pins,
  input  logic             edge_we,
  input  logic             en_we,
  input  logic             pend_we,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] edge_sel,
  output logic [WIDTH-1:0] en_n,
  output logic [WIDTH-1:0] pend,
  output logic             irq,
  output logic             wake
);

  localparam int ARM = 3;

  logic [WIDTH-1:0] sync1, sync2, prev;
  logic [ARM-1:0]   arm;
  logic [WIDTH-1:0] rise, fall, hit, clr, fresh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
      prev  <= '0;
      arm   <= '0;
    end else begin
      sync1 <= pins;
      sync2 <= sync1;
      prev  <= sync2;
      arm   <= {arm[ARM-2:0], 1'b1};
    end
  end

  assign rise  = sync2 & ~prev;
  assign fall  = ~sync2 & prev;
  assign hit   = (edge_sel & fall) | (~edge_sel & rise);
  assign clr   = pend_we ? wdata : '0;
  assign fresh = hit & ~en_n & ~(pend & ~clr) & {WIDTH{arm[ARM-1]}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edge_sel <= '1;
      en_n     <= '1;
      pend     <= '0;
      irq      <= 1'b0;
    end else begin
      if (edge_we) edge_sel <= wdata;
      if (en_we)   en_n     <= wdata;
      pend <= (pend & ~clr) | fresh;
      irq  <= |fresh;
    end
  end

  assign wake = |(pend & ~en_n);

endmodule

// File: rtl/pin_edge_wake_chk.sv
module pin_edge_wake_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pend_we,
  input logic [WIDTH-1:0] en_n,
  input logic [WIDTH-1:0] pend,
  input logic             irq,
  input logic             wake
);

  a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_we |=> ((~pend & $past(pend)) == '0));

  a_r3_disabled_no_set: assert property (@(posedge clk) disable iff (!rst_n)
    (&en_n) |=> ((pend & ~$past(pend)) == '0));

  a_r8_irq_with_pend: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (pend != '0));

  a_r9_wake_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (pend == '0) |-> !wake);

  a_r9_wake_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (&en_n) |-> !wake);

endmodule

bind pin_edge_wake pin_edge_wake_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .pend_we(pend_we), .en_n(en_n),
  .pend(pend), .irq(irq), .wake(wake)
);

// File: tb/pin_edge_wake_test.sv
module pin_edge_wake_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] pins = '0;
  logic       edge_we = 1'b0, en_we = 1'b0, pend_we = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] edge_sel, en_n, pend;
  logic       irq, wake;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  pin_edge_wake #(.WIDTH(8)) uut (
    .clk(clk), .rst_n(rst_n), .pins(pins), .edge_we(edge_we), .en_we(en_we),
    .pend_we(pend_we), .wdata(wdata), .edge_sel(edge_sel), .en_n(en_n),
    .pend(pend), .irq(irq), .wake(wake)
  );

  // fields: edge_sel, en_n, clear mask, pins, expected pend
  localparam logic [39:0] VEC [8] = '{
    {8'h00, 8'h00, 8'h00, 8'h0F, 8'h0F},
    {8'h00, 8'h00, 8'hFF, 8'hFF, 8'hF0},
    {8'hFF, 8'h0F, 8'hFF, 8'h00, 8'hF0},
    {8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'h00},
    {8'hAA, 8'h00, 8'h00, 8'h55, 8'hAA},
    {8'hAA, 8'h00, 8'h00, 8'hAA, 8'hAA},
    {8'h00, 8'h00, 8'h0F, 8'hFF, 8'hF5},
    {8'h00, 8'hFF, 8'h00, 8'h00, 8'hF5}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int which, input logic [7:0] d);
    @(negedge clk);
    wdata = d;
    edge_we = (which == 0);
    en_we   = (which == 1);
    pend_we = (which == 2);
    @(negedge clk);
    edge_we = 1'b0; en_we = 1'b0; pend_we = 1'b0;
  endtask

  task automatic count_irq(input int n, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (irq) c++;
    end
  endtask

  initial begin
    #200000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int c;
    repeat (3) @(negedge clk);
    chk("R1 edge_sel", edge_sel, 8'hFF);
    chk("R1 en_n", en_n, 8'hFF);
    chk("R1 pend", pend, 8'h00);
    chk("R1 irq/wake", {irq, wake}, 2'b00);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    wr(0, 8'h3C);
    chk("R10 edge_sel write", edge_sel, 8'h3C);
    wr(1, 8'hC3);
    chk("R10 en_n write", en_n, 8'hC3);

    for (int v = 0; v < 8; v++) begin
      wr(0, VEC[v][39:32]);
      wr(1, VEC[v][31:24]);
      wr(2, VEC[v][23:16]);
      pins = VEC[v][15:8];
      repeat (5) @(negedge clk);
      chk($sformatf("R2 R3 R5 vec%0d pend", v), pend, VEC[v][7:0]);
      chk($sformatf("R9 vec%0d wake", v), wake, |(VEC[v][7:0] & ~VEC[v][31:24]));
    end

    // latency and pulse shape
    wr(0, 8'h00); wr(1, 8'h00); pins = 8'h00; wr(2, 8'hFF);
    repeat (4) @(negedge clk);
    pins = 8'h01;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    chk("R4 not yet pend", pend, 8'h00);
    chk("R4 not yet irq", irq, 1'b0);
    @(negedge clk);
    chk("R4 pend at k+2", pend, 8'h01);
    chk("R8 irq at k+2", irq, 1'b1);
    @(negedge clk);
    chk("R8 irq one cycle", irq, 1'b0);

    // suppression while pending
    pins = 8'h00;
    count_irq(4, c);
    pins = 8'h01;
    count_irq(6, c);
    chk("R6 no irq while pending", c, 0);
    chk("R6 pend kept", pend, 8'h01);

    // clear and set in same cycle
    pins = 8'h00;
    repeat (4) @(negedge clk);
    pins = 8'h01;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    wdata = 8'h01; pend_we = 1'b1;
    @(negedge clk);
    pend_we = 1'b0;
    chk("R7 set wins pend", pend, 8'h01);
    chk("R7 set wins irq", irq, 1'b1);

    // write-one-to-clear semantics
    wr(2, 8'h00);
    chk("R5 zero write keeps", pend, 8'h01);
    wr(2, 8'hFE);
    chk("R5 other bits keep", pend, 8'h01);
    wr(2, 8'h01);
    chk("R5 one write clears", pend, 8'h00);

    // disabled pin: no irq
    wr(1, 8'hFF);
    pins = 8'h00;
    repeat (4) @(negedge clk);
    pins = 8'h01;
    count_irq(6, c);
    chk("R3 disabled no irq", c, 0);
    chk("R3 disabled no pend", pend, 8'h00);

    // opposite polarity ignored
    wr(1, 8'h00); wr(0, 8'h01);
    pins = 8'h00;
    count_irq(6, c);
    chk("R2 falling selected irq", c, 1);
    pins = 8'h01;
    wr(2, 8'hFF);
    count_irq(6, c);
    chk("R2 rising ignored", c, 0);
    chk("R2 rising ignored pend", pend, 8'h00);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule